// File: doc/BRIEF.md
# Peripheral Freeze Controller

This block drives the freeze lines that stop five on-chip peripherals: the wakeup timer, the software timer, the radio master clock, the watchdog and the DMA engine. Software holds a freeze state of one bit per peripheral. It changes that state through two write-only views. One view raises bits when 1s are written to it. The other view drops bits when 1s are written to it. Reading either view returns the current state. A third register holds a debug-freeze enable. This enable decides what a CPU debug halt does: it can stop every peripheral, or it can leave each peripheral on its software state. The watchdog follows its own rules in both cases. It is always frozen during a halt. A software request to freeze it is refused while the watchdog runs in its NMI mode.

The register interface is a decoded, single-cycle one. Each register has its own write strobe, and all strobes share one write data bus. Several strobes may be high in the same cycle. A write changes the state at the next rising clock edge. The freeze outputs are combinational in that state, the halt flag and the enable. Reads are combinational on a read-select input. The interface carries no stream data, so it has no valid/ready handshake. The timers themselves are not part of this block.

Top module: `freeze_ctrl`

## Requirements
- R1: After reset the freeze state is 0 and the debug-freeze enable is 1. With the CPU not halted, every freeze output is then 0.
- R2: Peripheral bit positions are 0 for the wakeup timer, 1 for the software timer, 2 for the radio master clock, 3 for the watchdog and 4 for the DMA. A cycle with `set_we` high and 1 in a bit of `wdata` sets that state bit at the next edge.
- R3: A 0 in `wdata` during a set or clear write leaves the matching state bit unchanged. A cycle with no write strobe leaves the whole state unchanged.
- R4: A cycle with `clr_we` high and 1 in a bit of `wdata` clears that state bit at the next edge.
- R5: If a bit is 1 for both the set and the clear strobe in one cycle, the set wins and the bit ends up 1.
- R6: While `wdog_nmi_mode` is 1, a set request on bit 3 is ignored. A clear request on bit 3 still takes effect.
- R7: With the debug-freeze enable at 1 and `cpu_halted` high, all five freeze outputs are 1.
- R8: With the debug-freeze enable at 0 and `cpu_halted` high, each freeze output equals its state bit, except the watchdog output (bit 3), which is 1.
- R9: With `cpu_halted` low, each freeze output equals its state bit.
- R10: `rdata` shows the state in bits 4:0 and zeros above when `rd_sel` is 0 (set view) or 1 (clear view). It shows the debug-freeze enable in bit 0 and zeros above when `rd_sel` is 2. It is all zeros when `rd_sel` is 3.
- R11: A cycle with `dbg_we` high loads `wdata` bit 0 into the debug-freeze enable at the next edge.
- R12: `frz_state` always equals the software freeze state, whatever the halt flag and the debug-freeze enable are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_we | input | 1 | Write strobe of the set view |
| clr_we | input | 1 | Write strobe of the clear view |
| dbg_we | input | 1 | Write strobe of the debug-freeze enable register |
| wdata | input | N_PERIPH (5) | Write data shared by all strobes, one bit per peripheral |
| rd_sel | input | 2 | Read select: 0 set view, 1 clear view, 2 debug enable, 3 none |
| rdata | output | DATA_W (16) | Read data for the selected register |
| cpu_halted | input | 1 | CPU is halted in debug |
| wdog_nmi_mode | input | 1 | Watchdog runs in NMI mode; blocks a software watchdog freeze |
| frz_out | output | N_PERIPH (5) | Freeze lines to the peripherals |
| frz_state | output | N_PERIPH (5) | Software freeze state |

## Verification
The bench uses the default parameters. These are five peripherals, the watchdog at bit 3 and a 16-bit read bus. With them, every peripheral's set, clear and halt path can be reached. The watchdog exceptions in the set path and the halt path are driven on their real bit, and the zero padding of the read data is checked. A behavioural model follows the state and the enable and is compared on every cycle. Directed phases set both strobes in the same cycle, request a watchdog freeze while NMI mode is on, and halt the CPU under both enable values. A long run of random strobes, halt flags and mode bits follows.

// File: rtl/freeze_pkg.sv
package freeze_pkg;
  localparam int unsigned SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_SETVIEW = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CLRVIEW = 2'd1;
  localparam logic [SEL_W-1:0] SEL_DBGEN   = 2'd2;
endpackage

// File: rtl/freeze_state_reg.sv
module freeze_state_reg #(
  parameter int unsigned N_PERIPH = 5,
  parameter int unsigned WDOG_BIT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_we,
  input  logic                clr_we,
  input  logic [N_PERIPH-1:0] wdata,
  input  logic                wdog_nmi_mode,
  output logic [N_PERIPH-1:0] state
);
  logic [N_PERIPH-1:0] set_mask, clr_mask, wd_block;

  // Mask of the state bits the NMI mode protects from a software set.
  generate
    for (genvar i = 0; i < N_PERIPH; i++) begin : g_block
      if (i == WDOG_BIT) begin : g_wd
        assign wd_block[i] = wdog_nmi_mode;
      end else begin : g_other
        assign wd_block[i] = 1'b0;
      end
    end
  endgenerate

  assign set_mask = set_we ? (wdata & ~wd_block) : '0;
  assign clr_mask = clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= '0;
    else        state <= (state & ~clr_mask) | set_mask;
  end

  assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(state));

  generate
    for (genvar i = 0; i < N_PERIPH; i++) begin : g_chk
      localparam bit IS_WD = (i == WDOG_BIT);
      assert_set_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && wdata[i] && (!IS_WD || !wdog_nmi_mode)) |=> state[i]);
      assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && wdata[i] && !(set_we && (!IS_WD || !wdog_nmi_mode))) |=> !state[i]);
      assert_zero_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wdata[i] |=> $stable(state[i]));
      if (IS_WD) begin : g_wdchk
        assert_nmi_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (set_we && wdata[i] && wdog_nmi_mode && !state[i]) |=> !state[i]);
      end
    end
  endgenerate
endmodule

// File: rtl/freeze_dbg_reg.sv
module freeze_dbg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_we,
  input  logic wbit,
  output logic dbg_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dbg_en <= 1'b1;
    else if (dbg_we) dbg_en <= wbit;
  end

  assert_dbg_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_we |=> (dbg_en == $past(wbit)));
  assert_dbg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_we |=> $stable(dbg_en));
endmodule

// File: rtl/freeze_out_gen.sv
module freeze_out_gen #(
  parameter int unsigned N_PERIPH = 5,
  parameter int unsigned WDOG_BIT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_PERIPH-1:0] state,
  input  logic                cpu_halted,
  input  logic                dbg_en,
  output logic [N_PERIPH-1:0] frz_out
);
  generate
    for (genvar i = 0; i < N_PERIPH; i++) begin : g_line
      logic halt_force;
      if (i == WDOG_BIT) begin : g_wd
        assign halt_force = cpu_halted;
      end else begin : g_other
        assign halt_force = cpu_halted & dbg_en;
      end
      assign frz_out[i] = state[i] | halt_force;
    end
  endgenerate

  assert_halt_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_halted && dbg_en) |-> (&frz_out));
  assert_halt_wdog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_halted |-> frz_out[WDOG_BIT]);
  assert_run_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_halted |-> (frz_out == state));
endmodule

// File: rtl/freeze_rd_mux.sv
module freeze_rd_mux
  import freeze_pkg::*;
#(
  parameter int unsigned N_PERIPH = 5,
  parameter int unsigned DATA_W   = 16
) (
  input  logic [SEL_W-1:0]    rd_sel,
  input  logic [N_PERIPH-1:0] state,
  input  logic                dbg_en,
  output logic [DATA_W-1:0]   rdata
);
  localparam int unsigned PAD_ST = DATA_W - N_PERIPH;
  localparam int unsigned PAD_EN = DATA_W - 1;

  always_comb begin
    unique case (rd_sel)
      SEL_SETVIEW, SEL_CLRVIEW: rdata = {{PAD_ST{1'b0}}, state};
      SEL_DBGEN:                rdata = {{PAD_EN{1'b0}}, dbg_en};
      default:                  rdata = '0;
    endcase
  end

  initial assert (DATA_W > N_PERIPH);
endmodule

// File: rtl/freeze_ctrl.sv
module freeze_ctrl #(
  parameter int unsigned N_PERIPH = 5,
  parameter int unsigned WDOG_BIT = 3,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                set_we,
  input  logic                clr_we,
  input  logic                dbg_we,
  input  logic [N_PERIPH-1:0] wdata,
  input  logic [1:0]          rd_sel,
  output logic [DATA_W-1:0]   rdata,
  input  logic                cpu_halted,
  input  logic                wdog_nmi_mode,
  output logic [N_PERIPH-1:0] frz_out,
  output logic [N_PERIPH-1:0] frz_state
);
  logic [N_PERIPH-1:0] state;
  logic                dbg_en;

  freeze_state_reg #(.N_PERIPH(N_PERIPH), .WDOG_BIT(WDOG_BIT)) u_state (
    .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .wdata(wdata), .wdog_nmi_mode(wdog_nmi_mode), .state(state));

  freeze_dbg_reg u_dbg (
    .clk(clk), .rst_n(rst_n), .dbg_we(dbg_we), .wbit(wdata[0]), .dbg_en(dbg_en));

  freeze_out_gen #(.N_PERIPH(N_PERIPH), .WDOG_BIT(WDOG_BIT)) u_out (
    .clk(clk), .rst_n(rst_n), .state(state), .cpu_halted(cpu_halted),
    .dbg_en(dbg_en), .frz_out(frz_out));

  freeze_rd_mux #(.N_PERIPH(N_PERIPH), .DATA_W(DATA_W)) u_rd (
    .rd_sel(rd_sel), .state(state), .dbg_en(dbg_en), .rdata(rdata));

  assign frz_state = state;

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && clr_we && wdata[0]) |=> frz_state[0]);
  assert_state_under_halt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> (frz_state == $past(frz_state)));
endmodule

// File: tb/tb_freeze_ctrl.sv
`timescale 1ns/1ps
module tb_freeze_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_we = 0, clr_we = 0, dbg_we = 0, cpu_halted = 0, wdog_nmi_mode = 0;
  logic [4:0] wdata = '0;
  logic [1:0] rd_sel = '0;
  logic [15:0] rdata;
  logic [4:0] frz_out, frz_state;

  always #2.5 clk = ~clk;

  freeze_ctrl dut (.clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
    .dbg_we(dbg_we), .wdata(wdata), .rd_sel(rd_sel), .rdata(rdata),
    .cpu_halted(cpu_halted), .wdog_nmi_mode(wdog_nmi_mode),
    .frz_out(frz_out), .frz_state(frz_state));

  int errors = 0, checks = 0;
  bit chk_on = 0;
  string cur_req = "R1";
  bit [4:0] m_state = '0;
  bit m_dbg = 1'b1;

  // Behavioural reference model, updated on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = '0; m_dbg = 1'b1;
    end else begin
      bit [4:0] nxt;
      nxt = m_state;
      for (int b = 0; b < 5; b++) begin
        if (clr_we && wdata[b]) nxt[b] = 1'b0;
        if (set_we && wdata[b] && !(b == 3 && wdog_nmi_mode)) nxt[b] = 1'b1;
      end
      m_state = nxt;
      if (dbg_we) m_dbg = wdata[0];
    end
  end

  function automatic bit [4:0] exp_out();
    bit [4:0] e;
    for (int b = 0; b < 5; b++)
      e[b] = m_state[b] | (cpu_halted & (m_dbg | (b == 3)));
    return e;
  endfunction

  function automatic bit [15:0] exp_rd();
    case (rd_sel)
      2'd0, 2'd1: return {11'd0, m_state};
      2'd2:       return {15'd0, m_dbg};
      default:    return 16'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && chk_on) begin
      chk({cur_req, " frz_out"}, {11'd0, frz_out}, {11'd0, exp_out()});
      chk({cur_req, " frz_state R12"}, {11'd0, frz_state}, {11'd0, m_state});
      chk({cur_req, " rdata R10"}, rdata, exp_rd());
    end
  end

  task automatic drive(bit s, bit c, bit d, bit [4:0] w, bit h, bit n, bit [1:0] sel);
    @(negedge clk);
    set_we = s; clr_we = c; dbg_we = d; wdata = w;
    cpu_halted = h; wdog_nmi_mode = n; rd_sel = sel;
  endtask

  task automatic idle(bit h, bit n, bit [1:0] sel);
    drive(0, 0, 0, 5'd0, h, n, sel);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    cur_req = "R1";
    chk("R1 reset frz_out", {11'd0, frz_out}, 16'd0);
    chk("R1 reset state", {11'd0, frz_state}, 16'd0);
    rd_sel = 2'd2; #0.5;
    chk("R1 reset dbg enable", rdata, 16'd1);
    chk_on = 1;

    cur_req = "R2";
    drive(1, 0, 0, 5'b00101, 0, 0, 0);
    idle(0, 0, 0); #1;
    chk("R2 set bits 0,2", {11'd0, frz_state}, 16'h0005);
    drive(1, 0, 0, 5'b11010, 0, 0, 1);
    idle(0, 0, 1);

    cur_req = "R3";
    drive(1, 0, 0, 5'b00000, 0, 0, 0);
    drive(0, 1, 0, 5'b00000, 0, 0, 0);
    idle(0, 0, 0); #1;
    chk("R3 zero writes ignored", {11'd0, frz_state}, 16'h001f);

    cur_req = "R4";
    drive(0, 1, 0, 5'b01001, 0, 0, 0);
    idle(0, 0, 0); #1;
    chk("R4 clear bits 0,3", {11'd0, frz_state}, 16'h0016);

    cur_req = "R5";
    drive(1, 1, 0, 5'b00001, 0, 0, 0);
    idle(0, 0, 0); #1;
    chk("R5 set wins bit0", {11'd0, frz_state}, 16'h0017);
    drive(0, 1, 0, 5'b11111, 0, 0, 0);
    idle(0, 0, 0);

    cur_req = "R6";
    drive(1, 0, 0, 5'b01000, 0, 1, 0);
    idle(0, 1, 0); #1;
    chk("R6 wdog set blocked in NMI mode", {11'd0, frz_state}, 16'h0000);
    drive(1, 0, 0, 5'b01010, 0, 0, 0);
    idle(0, 1, 0); #1;
    chk("R6 wdog set allowed", {11'd0, frz_state}, 16'h000a);
    drive(0, 1, 0, 5'b01000, 0, 1, 0);
    idle(0, 1, 0); #1;
    chk("R6 wdog clear in NMI mode", {11'd0, frz_state}, 16'h0002);

    cur_req = "R7";
    idle(1, 0, 2); #1;
    chk("R7 halt freezes all", {11'd0, frz_out}, 16'h001f);

    cur_req = "R11";
    drive(0, 0, 1, 5'b00000, 1, 0, 2);
    idle(1, 0, 2); #1;
    chk("R11 dbg enable cleared", rdata, 16'd0);

    cur_req = "R8";
    idle(1, 0, 0); #1;
    chk("R8 halt with enable off", {11'd0, frz_out}, 16'h000a);

    cur_req = "R9";
    idle(0, 0, 0); #1;
    chk("R9 running follows state", {11'd0, frz_out}, 16'h0002);

    cur_req = "R10";
    for (int s = 0; s < 4; s++) idle(0, 0, s[1:0]);
    idle(0, 0, 3); #1;
    chk("R10 sel 3 reads zero", rdata, 16'd0);

    cur_req = "mixed R2/R4/R5/R6/R7/R8/R11";
    for (int k = 0; k < 3000; k++) begin
      bit [31:0] r;
      r = $urandom;
      drive(r[0], r[1], (r[7:2] == 0), r[12:8], r[13] & r[14], r[15], r[17:16]);
    end
    idle(0, 0, 0);
    @(negedge clk); #2;
    chk_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule